// File: doc/BRIEF.md
# Multi-Format PCM Serial Audio Receiver

This block takes stereo PCM audio from a three-wire serial link. The wires are a bit clock, a word-select line that tells the left channel from the right, and one data line. The receiver runs on the bit clock. Each left/right pair leaves the block as two parallel 24-bit words, marked by a single-cycle strobe.

One shift engine serves all three framings: I2S, left-justified and right-justified. A 3-bit format code picks the framing and the word length at run time. The core takes a new code only when a left half-frame starts, so a frame never mixes two formats. Words shorter than 24 bits are placed at the top of the output word, with zeros in the unused low bits, so two's-complement signs stay at bit 23.

Format codes: 000 = I2S 24-bit, 001 = I2S 16-bit, 010 = left-justified 24-bit, 011 = left-justified 16-bit, 100 = right-justified 24-bit, 101 = right-justified 20-bit, 110 = right-justified 16-bit, 111 = I2S 24-bit.

Top module: `pcmSerialRx`

## Requirements
- R1: Every input (data, word select and format code) is sampled on the rising edge of `bitClk`.
- R2: While `rstN` is low, `leftWord` and `rightWord` are zero and `frameValid` is low. The active format is 24-bit I2S (code 000) until the first word-select transition.
- R3: In I2S framing (codes 000, 001, 111), word select low marks the left channel. The MSB is the bit sampled on the second rising edge after a word-select transition, and the following bits come MSB first.
- R4: In left-justified framing (codes 010, 011), word select high marks the left channel. The MSB is the bit sampled on the first rising edge after a word-select transition.
- R5: In right-justified framing (codes 100, 101, 110), word select high marks the left channel. The LSB is the last bit sampled before the word-select transition, and only the final N bits of the half-frame are kept.
- R6: N is 24, 20 or 16 as the format code gives. An N-bit word appears in bits 23 down to 24-N, with zeros below it. In I2S and left-justified framing, bits after the N-th are ignored.
- R7: `frameValid` is high for exactly one cycle, on the cycle after the rising edge that ends the right half. At that point `leftWord` and `rightWord` present the pair together, and they hold their values until the next pulse.
- R8: The format code is taken only on the rising edge that starts a left half-frame, where left is judged by the polarity of the presented code. Changes to the code at other times do not affect the frame in progress.
- R9: After reset, no pulse is issued until a complete left half and a complete right half have been received, each of them begun by a word-select transition.
- R10: Samples are two's-complement. The received MSB (the sign) always lands in bit 23 of the output word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bitClk | input | 1 | Serial bit clock, also the block clock |
| rstN | input | 1 | Active-low synchronous reset |
| wordClk | input | 1 | Left/right word select |
| serData | input | 1 | Serial audio data, MSB first |
| fmtCode | input | 3 | Framing and word-length code |
| leftWord | output | 24 | Left sample, left-aligned |
| rightWord | output | 24 | Right sample, left-aligned |
| frameValid | output | 1 | One-cycle strobe for a new stereo pair |

## Verification
The assertions assume that every half-frame lasts at least N+1 bit clocks, so the I2S delay slot and the whole word fit before the next transition. They also assume that the format code only changes between halves or back to the value it had at the last transition. The stimulus makes every slot N+1 to N+8 bits long. Mid-half it writes a junk code and puts the real code back on the last bit before each transition. Whenever the next frame would begin at the current word-select level, it inserts a short half of the opposite level, so that every frame begins with a real transition.

// File: rtl/pcmRxPkg.sv
package pcmRxPkg;

  localparam int unsigned FMT_W = 3;

  typedef enum logic [1:0] {
    KIND_I2S = 2'd0,
    KIND_LJ  = 2'd1,
    KIND_RJ  = 2'd2
  } frameKindE;

  // control-to-datapath strobes
  typedef struct packed {
    logic restart;    // word-select edge: start a fresh half
    logic keepFirst;  // bit on the edge cycle belongs to the new word
    logic shift;      // shift current bit in
    logic toLeft;     // closing half is a left word
    logic toRight;    // closing half is a right word, pair complete
  } strobeT;

  function automatic frameKindE codeKind(logic [FMT_W-1:0] c);
    case (c)
      3'b010, 3'b011:         return KIND_LJ;
      3'b100, 3'b101, 3'b110: return KIND_RJ;
      default:                return KIND_I2S;
    endcase
  endfunction

  function automatic int unsigned codeLen(logic [FMT_W-1:0] c, int unsigned full);
    case (c)
      3'b001, 3'b011, 3'b110: return full - 8;
      3'b101:                 return full - 4;
      default:                return full;
    endcase
  endfunction

  // word-select level that marks the left channel
  function automatic logic leftLevel(frameKindE k);
    return (k == KIND_I2S) ? 1'b0 : 1'b1;
  endfunction

endpackage

// File: rtl/pcmRxCtrl.sv
module pcmRxCtrl
  import pcmRxPkg::*;
#(
  parameter int unsigned WORD_W = 24,
  localparam int unsigned CNT_W = $clog2(WORD_W + 1)
) (
  input  logic             bitClk,
  input  logic             rstN,
  input  logic             wordClk,
  input  logic [FMT_W-1:0] fmtCode,
  output strobeT           stb,
  output logic [CNT_W-1:0] alignShift
);

  logic             armed, prevWc, started, haveLeft;
  logic [FMT_W-1:0] fmtReg, fmtNext;
  logic [CNT_W-1:0] nTaken, lenBits;
  frameKindE        curKind, nextKind;
  logic             detect, finishingLeft;

  always_comb begin
    curKind       = codeKind(fmtReg);
    lenBits       = CNT_W'(codeLen(fmtReg, WORD_W));
    detect        = armed && (wordClk != prevWc);
    finishingLeft = (prevWc == leftLevel(curKind));
    fmtNext       = (wordClk == leftLevel(codeKind(fmtCode))) ? fmtCode : fmtReg;
    nextKind      = codeKind(fmtNext);
    stb.restart   = detect;
    stb.keepFirst = (nextKind != KIND_I2S);
    stb.shift     = !detect && ((curKind == KIND_RJ) || (nTaken < lenBits));
    stb.toLeft    = detect && started && finishingLeft;
    stb.toRight   = detect && started && !finishingLeft && haveLeft;
    alignShift    = CNT_W'(WORD_W) - lenBits;
  end

  always_ff @(posedge bitClk) begin
    if (!rstN) begin
      armed    <= 1'b0;
      prevWc   <= 1'b0;
      started  <= 1'b0;
      haveLeft <= 1'b0;
      fmtReg   <= '0;
      nTaken   <= '0;
    end else begin
      armed  <= 1'b1;
      prevWc <= wordClk;
      if (detect) begin
        started <= 1'b1;
        fmtReg  <= fmtNext;
        nTaken  <= stb.keepFirst ? CNT_W'(1) : '0;
      end else if (stb.shift && curKind != KIND_RJ) begin
        nTaken <= nTaken + CNT_W'(1);
      end
      if (stb.toLeft)       haveLeft <= 1'b1;
      else if (stb.toRight) haveLeft <= 1'b0;
    end
  end

  // R8: active format only moves at a half-frame boundary
  a_r8_fmt_hold: assert property (@(posedge bitClk) disable iff (!rstN)
    !detect |=> $stable(fmtReg));

  // R2: reset default is 24-bit I2S until the first transition
  a_r2_reset_fmt: assert property (@(posedge bitClk) disable iff (!rstN)
    !started |-> (fmtReg == 3'b000));

  // R6: I2S / left-justified capture never exceeds the word length
  a_r6_take_limit: assert property (@(posedge bitClk) disable iff (!rstN)
    (curKind != KIND_RJ) |-> (nTaken <= lenBits));

endmodule

// File: rtl/pcmRxData.sv
module pcmRxData
  import pcmRxPkg::*;
#(
  parameter int unsigned WORD_W = 24,
  localparam int unsigned CNT_W = $clog2(WORD_W + 1)
) (
  input  logic              bitClk,
  input  logic              rstN,
  input  logic              serData,
  input  strobeT            stb,
  input  logic [CNT_W-1:0]  alignShift,
  output logic [WORD_W-1:0] leftWord,
  output logic [WORD_W-1:0] rightWord,
  output logic              frameValid
);

  logic [WORD_W-1:0] shiftReg, leftHold, aligned;

  // dropping bits above N and left-aligning are one shift
  always_comb aligned = shiftReg << alignShift;

  always_ff @(posedge bitClk) begin
    if (!rstN) begin
      shiftReg   <= '0;
      leftHold   <= '0;
      leftWord   <= '0;
      rightWord  <= '0;
      frameValid <= 1'b0;
    end else begin
      if (stb.restart)    shiftReg <= stb.keepFirst ? WORD_W'(serData) : '0;
      else if (stb.shift) shiftReg <= {shiftReg[WORD_W-2:0], serData};
      if (stb.toLeft) leftHold <= aligned;
      if (stb.toRight) begin
        leftWord  <= leftHold;
        rightWord <= aligned;
      end
      frameValid <= stb.toRight;
    end
  end

  // R7: strobe lasts one cycle
  a_r7_single_pulse: assert property (@(posedge bitClk) disable iff (!rstN)
    frameValid |=> !frameValid);

  // R7: outputs move only together with the strobe
  a_r7_hold_words: assert property (@(posedge bitClk) disable iff (!rstN)
    !frameValid |-> ($stable(leftWord) && $stable(rightWord)));

  // R6: padding below a short word is zero
  a_r6_zero_pad: assert property (@(posedge bitClk) disable iff (!rstN)
    frameValid |-> ((rightWord & ((WORD_W'(1) << $past(alignShift)) - WORD_W'(1))) == '0));

endmodule

// File: rtl/pcmSerialRx.sv
module pcmSerialRx
  import pcmRxPkg::*;
#(
  parameter int unsigned WORD_W = 24
) (
  input  logic              bitClk,
  input  logic              rstN,
  input  logic              wordClk,
  input  logic              serData,
  input  logic [2:0]        fmtCode,
  output logic [WORD_W-1:0] leftWord,
  output logic [WORD_W-1:0] rightWord,
  output logic              frameValid
);

  localparam int unsigned CNT_W = $clog2(WORD_W + 1);

  strobeT           stb;
  logic [CNT_W-1:0] alignShift;

  pcmRxCtrl #(.WORD_W(WORD_W)) ctrl (
    .bitClk(bitClk), .rstN(rstN), .wordClk(wordClk), .fmtCode(fmtCode),
    .stb(stb), .alignShift(alignShift)
  );

  pcmRxData #(.WORD_W(WORD_W)) data (
    .bitClk(bitClk), .rstN(rstN), .serData(serData), .stb(stb),
    .alignShift(alignShift), .leftWord(leftWord), .rightWord(rightWord),
    .frameValid(frameValid)
  );

endmodule

// File: tb/pcmSerialRx_test.sv
module pcmSerialRx_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wc = 1'b0;
  logic        sd = 1'b0;
  logic [2:0]  fmt = 3'b000;
  logic [23:0] leftWord, rightWord;
  logic        frameValid;

  pcmSerialRx uut (
    .bitClk(clk), .rstN(rstN), .wordClk(wc), .serData(sd), .fmtCode(fmt),
    .leftWord(leftWord), .rightWord(rightWord), .frameValid(frameValid)
  );

  always #10 clk = ~clk;

  int          checks = 0, fails = 0;
  logic [23:0] expL [0:255];
  logic [23:0] expR [0:255];
  string       expTag [0:255];
  int          pushIdx = 0, popIdx = 0, validSeen = 0, cyc = 0;
  bit          prevValid = 1'b0, done = 1'b0;
  logic        curWc = 1'b0;
  logic [23:0] holdL = '0, holdR = '0;

  function automatic int kindOf(logic [2:0] c);
    if (c == 3'b010 || c == 3'b011) return 1;
    if (c == 3'b100 || c == 3'b101 || c == 3'b110) return 2;
    return 0;
  endfunction

  function automatic int lenOf(logic [2:0] c);
    if (c == 3'b001 || c == 3'b011 || c == 3'b110) return 16;
    if (c == 3'b101) return 20;
    return 24;
  endfunction

  function automatic logic leftLvl(logic [2:0] c);
    return (kindOf(c) == 0) ? 1'b0 : 1'b1;
  endfunction

  function automatic logic [23:0] alignExp(logic [23:0] v, int n);
    logic [31:0] m;
    m = (32'h1 << n) - 32'h1;
    return 24'(({8'h0, v} & m) << (24 - n));
  endfunction

  task automatic check(bit ok, string req, logic [23:0] act, logic [23:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      fails++;
      $display("FAIL R7 watchdog: actual %0d cycles expected below 150000", cyc);
      finishRun();
    end
  end

  // output monitor, samples away from the rising edge
  always @(negedge clk) begin
    if (rstN) begin
      if (frameValid) begin
        validSeen++;
        check(!prevValid, "R7 single-cycle strobe", 24'(prevValid), 24'h0);
        if (popIdx < pushIdx) begin
          check(leftWord == expL[popIdx], {expTag[popIdx], " left word"}, leftWord, expL[popIdx]);
          check(rightWord == expR[popIdx], {expTag[popIdx], " right word"}, rightWord, expR[popIdx]);
          popIdx++;
        end else begin
          check(1'b0, "R9 unexpected strobe", 24'h1, 24'h0);
        end
        holdL = leftWord;
        holdR = rightWord;
      end else begin
        check(leftWord == holdL && rightWord == holdR, "R7 words held between strobes",
              leftWord ^ holdL, 24'h0);
      end
      prevValid = frameValid;
    end
  end

  // one half-frame; the format code goes to a junk value mid-half (R8)
  task automatic sendHalf(logic [2:0] f, logic lvl, logic [23:0] val, int slot);
    int n, k;
    logic d;
    n = lenOf(f);
    k = kindOf(f);
    for (int p = 0; p < slot; p++) begin
      d = 1'($urandom);
      if (k == 0 && p >= 1 && p <= n) d = val[n - p];
      if (k == 1 && p < n) d = val[n - 1 - p];
      if (k == 2 && p >= slot - n) d = val[slot - 1 - p];
      @(negedge clk);
      wc = lvl;
      sd = d;
      if (p == 0) fmt = f;
      if (p == 3) fmt = 3'($urandom);
      if (p == slot - 1) fmt = f;
    end
  endtask

  task automatic sendFrame(logic [2:0] f, logic [23:0] lv, logic [23:0] rv, string tag);
    logic lvl;
    int n;
    lvl = leftLvl(f);
    n = lenOf(f);
    if (curWc == lvl) begin
      for (int p = 0; p < 8; p++) begin
        @(negedge clk);
        wc = ~curWc;
        sd = 1'($urandom);
      end
    end
    expL[pushIdx] = alignExp(lv, n);
    expR[pushIdx] = alignExp(rv, n);
    expTag[pushIdx] = tag;
    pushIdx++;
    sendHalf(f, lvl, lv, n + 1 + int'($urandom % 8));
    sendHalf(f, ~lvl, rv, n + 1 + int'($urandom % 8));
    curWc = ~lvl;
  endtask

  function automatic string tagOf(logic [2:0] f);
    if (lenOf(f) < 24) return "R1 R6";
    if (kindOf(f) == 0) return "R1 R3";
    if (kindOf(f) == 1) return "R1 R4";
    return "R1 R5";
  endfunction

  initial begin
    logic [2:0] rf;
    void'($urandom(32'd2024));
    // R2: reset state
    repeat (4) @(negedge clk);
    check(frameValid == 1'b0, "R2 strobe low in reset", 24'(frameValid), 24'h0);
    check(leftWord == 24'h0, "R2 left zero in reset", leftWord, 24'h0);
    check(rightWord == 24'h0, "R2 right zero in reset", rightWord, 24'h0);
    rstN = 1'b1;
    // R9: partial halves after reset give no strobe
    for (int p = 0; p < 6; p++) begin @(negedge clk); wc = 1'b0; sd = 1'($urandom); end
    for (int p = 0; p < 7; p++) begin @(negedge clk); wc = 1'b1; sd = 1'($urandom); end
    curWc = 1'b1;
    sendFrame(3'b000, 24'h800000, 24'h7FFFFF, "R10 sign");
    check(validSeen == 0, "R9 no strobe before first full pair", 24'(validSeen), 24'h0);
    // directed corners per code
    sendFrame(3'b001, 24'h008001, 24'h007FFE, "R6 R10 I2S short");
    sendFrame(3'b010, 24'hA5A5A5, 24'h5A5A5A, "R4 left-justified");
    sendFrame(3'b011, 24'hFF8000, 24'h00FFFF, "R6 R10 left-justified short");
    sendFrame(3'b100, 24'hFFFFFF, 24'h000000, "R5 right-justified");
    sendFrame(3'b101, 24'hF80001, 24'h07FFFF, "R5 R6 20-bit");
    sendFrame(3'b110, 24'h128000, 24'hEE7FFF, "R5 R6 16-bit");
    sendFrame(3'b111, 24'h123456, 24'h654321, "R3 alias code");
    sendFrame(3'b000, 24'h000001, 24'hFFFFFE, "R3 R8 I2S after change");
    // random traffic
    for (int i = 0; i < 40; i++) begin
      rf = 3'($urandom);
      sendFrame(rf, 24'($urandom), 24'($urandom), tagOf(rf));
    end
    // close the last right half
    for (int p = 0; p < 4; p++) begin @(negedge clk); wc = ~curWc; sd = 1'b0; end
    repeat (4) @(negedge clk);
    check(popIdx == pushIdx, "R7 one strobe per sent pair", 24'(popIdx), 24'(pushIdx));
    done = 1'b1;
    finishRun();
  end

endmodule